// File: doc/BRIEF.md
# Block Floating Point Scaling Controller

This block manages the dynamic range of a multi-pass radix-4 FFT data path. While a pass runs, the data path streams each 16-bit complex result through the block. The block measures how many redundant sign bits the largest component in the pass still carries. When a pass ends, the block turns that measurement into a left-shift amount, and the data path applies that shift to every word it reads during the next pass. The block also keeps the running total of shifts for the transform.

A configuration bit selects one word-growth policy for every pass after the first. The narrow option allows 2 bits of growth: it keeps more precision, but the data path can overflow. The wide option allows 3 bits of growth and can never overflow. A second configuration bit turns the block-floating scheme off. Both bits are captured when a transform starts.

When the last pass ends, the block presents a 4-bit scale tag. In the narrow option, an overflow reported by the data path turns the tag into the reserved value 15 and raises a request to zero every output bin.

Top module: `bfp_scale_ctrl`

## Requirements
- R1: A sample's headroom is the smaller of its two components' redundant sign bits. Redundant sign bits are the leading bits below the MSB that equal the MSB, in the range 0 to 15. The pass measure is the minimum headroom over all samples with `smp_valid` high between `pass_start` and `pass_end`, including a sample given in the same cycle as either strobe. The measure starts at 16 on `pass_start`.
- R2: On a `pass_end` with `pass_last` low, `shift_amt` takes the value min(pass measure, 4, remaining budget) from the next cycle. The value holds until the next such `pass_end` or `xform_start`.
- R3: The shift total for a transform never exceeds 15 in the wide option (`cfg_wide_growth`=1) or 14 in the narrow option.
- R4: One cycle after a `pass_end` with `pass_last` high, `tag_valid` goes high. `scale_tag` then shows the shift total, and both hold until the next `xform_start`. The last pass adds no shift.
- R5: In the narrow option, a sample with `smp_valid` and `smp_ovf` both high sets a sticky overflow. While the overflow is set, `scale_tag` reads 15, and `zero_bins` is high whenever `tag_valid` is high.
- R6: In the wide option, `smp_ovf` has no effect. `zero_bins` stays low and `scale_tag` shows the plain total.
- R7: With `cfg_bfp_off`=1, `shift_amt` stays 0 and the final tag is 0 whatever the samples are.
- R8: Both configuration bits are sampled only in the cycle `xform_start` is high. Later changes have no effect until the next transform starts.
- R9: After reset, `shift_amt`, `scale_tag`, `tag_valid` and `zero_bins` are all 0.
- R10: `xform_start` clears the total, the overflow, `tag_valid` and `shift_amt` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xform_start | input | 1 | Strobe that begins a transform and captures the configuration |
| pass_start | input | 1 | Strobe that begins a pass |
| pass_end | input | 1 | Strobe that ends a pass |
| pass_last | input | 1 | Qualifies `pass_end` as the end of the final pass |
| smp_valid | input | 1 | A result sample is present |
| smp_re | input | 16 | Real component of the result, two's complement |
| smp_im | input | 16 | Imaginary component of the result, two's complement |
| smp_ovf | input | 1 | Data path reports an overflow on this sample |
| cfg_wide_growth | input | 1 | 1 selects 3-bit growth, 0 selects 2-bit growth |
| cfg_bfp_off | input | 1 | 1 disables the compensating shifts |
| shift_amt | output | 3 | Left shift the data path applies during the current pass |
| scale_tag | output | 4 | Total shifts, or 15 for overflow |
| tag_valid | output | 1 | The transform has ended and the tag is final |
| zero_bins | output | 1 | Request to force all output bins to zero |

## Verification
The bench targets these corner cases:
- The all-ones and tiny-magnitude words, where an off-by-one in sign counting would give a shift one too large or too small.
- A sample given in the same cycle as `pass_end`, which a tracker that ignores it would miss.
- A pass with no samples at all, which should produce the full per-pass shift.
- Several passes of tiny data that run into the budget, where a design without the clip would report 16 or wrap around.
- A narrow-mode overflow that must turn the tag to 15 and raise `zero_bins`, and the same stimulus in the wide option, which a design that did not gate the overflow flag by mode would wrongly report.
- Mode changes part-way through a transform, which a design that does not latch the configuration would act on.

// File: rtl/bfp_pkg.sv
// Package: shared sizing constants of the block floating point controller.
// Assumes a 16-bit data path, at most 4 shifts per pass and a 4-bit tag.
package bfp_pkg;
    localparam int DATA_W    = 16;
    localparam int PASS_CAP  = 4;
    localparam int TOT_WIDE  = 15;
    localparam int TOT_NARW  = 14;
    localparam int CNT_W     = $clog2(DATA_W + 1);
    localparam int SHIFT_W   = $clog2(PASS_CAP + 1);
    localparam int TAG_W     = $clog2(TOT_WIDE + 1);
endpackage

// File: rtl/bfp_sign_count.sv
// Module: counts the redundant sign bits of one two's complement word.
// Assumes W >= 2; the result lies in 0 .. W-1 and is purely combinational.
module bfp_sign_count #(
    parameter int W   = bfp_pkg::DATA_W,
    parameter int CW  = bfp_pkg::CNT_W
) (
    input  logic [W-1:0]  val,
    output logic [CW-1:0] red
);
    // Walk down from below the MSB while bits match the sign.
    always_comb begin
        logic run;
        red = '0;
        run = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (val[i] == val[W-1])) red = red + 1'b1;
            else                              run = 1'b0;
        end
    end
endmodule

// File: rtl/bfp_pass_track.sv
// Module: keeps the smallest headroom seen during the current pass.
// Assumes pass_start opens a pass; a sample in the same cycle is included.
module bfp_pass_track #(
    parameter int W  = bfp_pkg::DATA_W,
    parameter int CW = bfp_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pass_start,
    input  logic          smp_valid,
    input  logic [W-1:0]  smp_re,
    input  logic [W-1:0]  smp_im,
    output logic [CW-1:0] trk_eff
);
    localparam logic [CW-1:0] TRK_MAX = CW'(W);

    logic [CW-1:0] red_c [2];
    logic [W-1:0]  comp  [2];
    logic [CW-1:0] trk_q;
    logic [CW-1:0] base;
    logic [CW-1:0] hroom;

    assign comp[0] = smp_re;
    assign comp[1] = smp_im;

    // One sign counter per complex component.
    for (genvar g = 0; g < 2; g++) begin : g_comp
        bfp_sign_count #(.W(W), .CW(CW)) u_cnt (.val(comp[g]), .red(red_c[g]));
    end

    // Combine the current sample with the running minimum.
    always_comb begin
        hroom   = (red_c[0] < red_c[1]) ? red_c[0] : red_c[1];
        base    = pass_start ? TRK_MAX : trk_q;
        trk_eff = (smp_valid && hroom < base) ? hroom : base;
    end

    // Hold the running minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= TRK_MAX;
        else        trk_q <= trk_eff;
    end
endmodule

// File: rtl/bfp_shift_budget.sv
// Module: turns each pass measure into a clipped shift, keeps the total,
// the sticky overflow and the end-of-transform flag.
// Assumes the configuration is captured on xform_start only.
module bfp_shift_budget #(
    parameter int CW       = bfp_pkg::CNT_W,
    parameter int SW       = bfp_pkg::SHIFT_W,
    parameter int TW       = bfp_pkg::TAG_W,
    parameter int PASS_CAP = bfp_pkg::PASS_CAP,
    parameter int TOT_WIDE = bfp_pkg::TOT_WIDE,
    parameter int TOT_NARW = bfp_pkg::TOT_NARW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xform_start,
    input  logic          pass_end,
    input  logic          pass_last,
    input  logic [CW-1:0] trk_eff,
    input  logic          ovf_hit,
    input  logic          cfg_wide,
    input  logic          cfg_off,
    output logic [SW-1:0] shift_q,
    output logic [TW-1:0] total_q,
    output logic          ovf_q,
    output logic          done_q,
    output logic          wide_q,
    output logic          off_q
);
    localparam logic [CW-1:0] CAP_P = CW'(PASS_CAP);

    logic [CW-1:0] cap_tot;
    logic [CW-1:0] room;
    logic [CW-1:0] cand;
    logic [CW-1:0] nxt;

    // Clip the measure to the per-pass cap and the remaining budget.
    always_comb begin
        cap_tot = wide_q ? CW'(TOT_WIDE) : CW'(TOT_NARW);
        room    = cap_tot - CW'(total_q);
        cand    = (trk_eff > CAP_P) ? CAP_P : trk_eff;
        nxt     = off_q ? '0 : ((cand > room) ? room : cand);
    end

    // Update configuration, shift, total, overflow and completion state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            total_q <= '0;
            ovf_q   <= 1'b0;
            done_q  <= 1'b0;
            wide_q  <= 1'b0;
            off_q   <= 1'b0;
        end else if (xform_start) begin
            shift_q <= '0;
            total_q <= '0;
            ovf_q   <= 1'b0;
            done_q  <= 1'b0;
            wide_q  <= cfg_wide;
            off_q   <= cfg_off;
        end else begin
            if (ovf_hit && !wide_q) ovf_q <= 1'b1;
            if (pass_end) begin
                if (pass_last) begin
                    done_q <= 1'b1;
                end else begin
                    shift_q <= SW'(nxt);
                    total_q <= total_q + TW'(nxt);
                end
            end
        end
    end
endmodule

// File: rtl/bfp_scale_ctrl.sv
// Module: top of the block floating point scaling controller.
// Assumes the data path applies shift_amt during each pass and raises
// smp_ovf alongside smp_valid when its 2-bit growth result overflowed.
module bfp_scale_ctrl #(
    parameter int W  = bfp_pkg::DATA_W,
    parameter int CW = bfp_pkg::CNT_W,
    parameter int SW = bfp_pkg::SHIFT_W,
    parameter int TW = bfp_pkg::TAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xform_start,
    input  logic          pass_start,
    input  logic          pass_end,
    input  logic          pass_last,
    input  logic          smp_valid,
    input  logic [W-1:0]  smp_re,
    input  logic [W-1:0]  smp_im,
    input  logic          smp_ovf,
    input  logic          cfg_wide_growth,
    input  logic          cfg_bfp_off,
    output logic [SW-1:0] shift_amt,
    output logic [TW-1:0] scale_tag,
    output logic          tag_valid,
    output logic          zero_bins
);
    logic [CW-1:0] trk_eff;
    logic [TW-1:0] total;
    logic          ovf;
    logic          wide_q;
    logic          off_q;

    bfp_pass_track #(.W(W), .CW(CW)) u_track (
        .clk(clk), .rst_n(rst_n), .pass_start(pass_start),
        .smp_valid(smp_valid), .smp_re(smp_re), .smp_im(smp_im),
        .trk_eff(trk_eff)
    );

    bfp_shift_budget #(.CW(CW), .SW(SW), .TW(TW)) u_budget (
        .clk(clk), .rst_n(rst_n), .xform_start(xform_start),
        .pass_end(pass_end), .pass_last(pass_last), .trk_eff(trk_eff),
        .ovf_hit(smp_valid && smp_ovf), .cfg_wide(cfg_wide_growth),
        .cfg_off(cfg_bfp_off), .shift_q(shift_amt), .total_q(total),
        .ovf_q(ovf), .done_q(tag_valid), .wide_q(wide_q), .off_q(off_q)
    );

    // Reserved all-ones code marks an overflow.
    assign scale_tag = ovf ? {TW{1'b1}} : total;
    // Zero request only once the transform is complete.
    assign zero_bins = tag_valid && ovf;
endmodule

// File: rtl/bfp_scale_ctrl_chk.sv
// Module: property checker for bfp_scale_ctrl, attached by bind below.
// Assumes the default sizing (4-shift cap, 4-bit tag).
module bfp_scale_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       xform_start,
    input logic       smp_valid,
    input logic       smp_ovf,
    input logic [2:0] shift_amt,
    input logic [3:0] scale_tag,
    input logic       tag_valid,
    input logic       zero_bins,
    input logic [3:0] total,
    input logic       ovf,
    input logic       wide_q,
    input logic       off_q
);
    assert_shift_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_amt <= 3'd4);
    assert_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |-> total <= 4'd14);
    assert_tag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && !xform_start && !(smp_valid && smp_ovf))
        |=> (tag_valid && $stable(scale_tag)));
    assert_zero_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        zero_bins |-> (scale_tag == 4'd15 && ovf));
    assert_wide_no_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wide_q |-> !zero_bins);
    assert_off_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        off_q |-> shift_amt == 3'd0);
    assert_start_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xform_start |=> (!tag_valid && shift_amt == 3'd0 && !zero_bins));
endmodule

bind bfp_scale_ctrl bfp_scale_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .xform_start(xform_start),
    .smp_valid(smp_valid), .smp_ovf(smp_ovf), .shift_amt(shift_amt),
    .scale_tag(scale_tag), .tag_valid(tag_valid), .zero_bins(zero_bins),
    .total(total), .ovf(ovf), .wide_q(wide_q), .off_q(off_q)
);

// File: tb/bfp_scale_ctrl_tb.sv
module bfp_scale_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {re, im, expected shift}
    localparam logic [34:0] VEC [NVEC] = '{
        {16'h0001, 16'h0001, 3'd4},
        {16'h4000, 16'h0000, 3'd0},
        {16'h2000, 16'h0000, 3'd1},
        {16'hF000, 16'h0800, 3'd3},
        {16'hFFFF, 16'hFFFF, 3'd4},
        {16'h1000, 16'h8000, 3'd0},
        {16'h0400, 16'h0200, 3'd4},
        {16'hE000, 16'h0000, 3'd2}
    };

    logic clk = 0, rst_n = 0;
    logic xform_start = 0, pass_start = 0, pass_end = 0, pass_last = 0;
    logic smp_valid = 0, smp_ovf = 0, cfg_wide_growth = 0, cfg_bfp_off = 0;
    logic [15:0] smp_re = 0, smp_im = 0;
    logic [2:0] shift_amt;
    logic [3:0] scale_tag;
    logic tag_valid, zero_bins;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfp_scale_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .xform_start(xform_start),
        .pass_start(pass_start), .pass_end(pass_end), .pass_last(pass_last),
        .smp_valid(smp_valid), .smp_re(smp_re), .smp_im(smp_im),
        .smp_ovf(smp_ovf), .cfg_wide_growth(cfg_wide_growth),
        .cfg_bfp_off(cfg_bfp_off), .shift_amt(shift_amt),
        .scale_tag(scale_tag), .tag_valid(tag_valid), .zero_bins(zero_bins)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic begin_xform(logic wide, logic off);
        @(negedge clk);
        xform_start = 1; cfg_wide_growth = wide; cfg_bfp_off = off;
        @(negedge clk);
        xform_start = 0;
    endtask

    // One pass: start strobe, then one sample in the pass_end cycle.
    task automatic one_pass(logic [15:0] re, logic [15:0] im, logic vld,
                            logic ovf, logic last);
        @(negedge clk);
        pass_start = 1;
        @(negedge clk);
        pass_start = 0; smp_valid = vld; smp_re = re; smp_im = im;
        smp_ovf = ovf; pass_end = 1; pass_last = last;
        @(negedge clk);
        smp_valid = 0; smp_ovf = 0; pass_end = 0; pass_last = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 shift", shift_amt, 0);
        chk("R9 tag", scale_tag, 0);
        chk("R9 valid", tag_valid, 0);
        chk("R9 zero", zero_bins, 0);
        rst_n = 1;

        // R1/R2 table of single-pass measures
        for (int i = 0; i < NVEC; i++) begin
            begin_xform(0, 0);
            one_pass(VEC[i][34:19], VEC[i][18:3], 1, 0, 0);
            chk("R1 R2 table shift", shift_amt, VEC[i][2:0]);
        end

        // R1 empty pass keeps the starting measure of 16, clipped to 4
        begin_xform(0, 0);
        one_pass(16'h4000, 16'h4000, 0, 0, 0);
        chk("R1 empty pass", shift_amt, 4);

        // R1 minimum across several samples in one pass
        begin_xform(0, 0);
        @(negedge clk); pass_start = 1; smp_valid = 1; smp_re = 16'h0100; smp_im = 0;
        @(negedge clk); pass_start = 0; smp_re = 16'h1000;
        @(negedge clk); smp_re = 16'h0002;
        @(negedge clk); smp_valid = 0; pass_end = 1;
        @(negedge clk); pass_end = 0;
        chk("R1 min of samples", shift_amt, 2);

        // R3/R4 narrow budget: 4,4,4,2 then last -> 14
        begin_xform(0, 0);
        for (int p = 0; p < 4; p++) one_pass(16'h0001, 16'h0000, 1, 0, 0);
        chk("R3 narrow clip", shift_amt, 2);
        chk("R4 not done yet", tag_valid, 0);
        one_pass(16'h0001, 16'h0000, 1, 0, 1);
        chk("R4 valid", tag_valid, 1);
        chk("R3 R4 narrow tag", scale_tag, 14);
        chk("R3 shift after last", shift_amt, 2);
        repeat (3) @(negedge clk);
        chk("R4 tag held", scale_tag, 14);

        // R3 wide budget -> 15, no zeroing
        begin_xform(1, 0);
        for (int p = 0; p < 4; p++) one_pass(16'h0001, 16'h0000, 1, 0, 0);
        chk("R3 wide clip", shift_amt, 3);
        one_pass(16'h0001, 16'h0000, 1, 0, 1);
        chk("R3 wide tag", scale_tag, 15);
        chk("R3 wide zero", zero_bins, 0);

        // R5 narrow overflow
        begin_xform(0, 0);
        one_pass(16'h0400, 16'h0000, 1, 0, 0);
        one_pass(16'h4000, 16'h0000, 1, 1, 1);
        chk("R5 tag", scale_tag, 15);
        chk("R5 zero", zero_bins, 1);

        // R10 clear on next start
        begin_xform(0, 0);
        chk("R10 valid", tag_valid, 0);
        chk("R10 tag", scale_tag, 0);
        chk("R10 zero", zero_bins, 0);

        // R6 wide ignores overflow
        begin_xform(1, 0);
        one_pass(16'h0400, 16'h0000, 1, 0, 0);
        one_pass(16'h4000, 16'h0000, 1, 1, 1);
        chk("R6 tag", scale_tag, 4);
        chk("R6 zero", zero_bins, 0);

        // R7 disabled scaling
        begin_xform(0, 1);
        one_pass(16'h0001, 16'h0000, 1, 0, 0);
        chk("R7 shift", shift_amt, 0);
        one_pass(16'h0001, 16'h0000, 1, 0, 1);
        chk("R7 tag", scale_tag, 0);

        // R8 configuration latched at start
        begin_xform(0, 0);
        cfg_wide_growth = 1; cfg_bfp_off = 1;
        for (int p = 0; p < 4; p++) one_pass(16'h0001, 16'h0000, 1, 0, 0);
        chk("R8 off ignored", shift_amt, 2);
        one_pass(16'h0001, 16'h0000, 1, 1, 1);
        chk("R8 narrow kept", scale_tag, 15);
        chk("R8 zero", zero_bins, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule